// File: doc/BRIEF.md
# CAN Bit Sampler with Edge Resynchronisation

This block turns an oversampled, already synchronised CAN receive line into a stream of bit decisions. It runs on a sample clock much faster than the bit rate. While idle it watches for the line to become dominant (logic 0). The first dominant sample starts a frame, and from then on the block places one sample point per bit period. A single-cycle strobe accompanies each registered bit value.

Timing is kept relative to the most recent recessive-to-dominant transition. The pending sample point is recomputed from that transition as edge time + (bits since edge × bit width) + sample offset. A transmitter whose rate is slightly off is therefore tracked without any time-quantum segmentation.

Stuff bits are not recognised here; every bit period yields a strobe. The frame decoder behind the sampler pulses `frame_done_i` at end of frame to send the sampler back to idle.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset, `bit_o` is 1 (recessive), `bit_strobe_o` and `sof_o` are 0, and the block is idle.
- R2: While idle, a clock edge that samples `rx_i` = 0 starts a frame. `sof_o` is high for exactly the next cycle. A recessive idle line never produces `sof_o` or a strobe.
- R3: Take the start-of-frame edge as edge E. The first bit is sampled at edge E + `sample_ofs_i`. `bit_strobe_o` is high and `bit_o` carries the value of `rx_i` at that edge, both during the cycle after it.
- R4: With no falling edge on the line, each following sample comes exactly `bit_width_i` clock edges after the previous one.
- R5: Sample N is pending. If `rx_i` goes from 1 to 0 at an edge T before sample N's edge, then sample N moves to T + `sample_ofs_i`. No sample is skipped and none is added.
- R6: A falling edge seen at the same clock edge as the pending sample is ignored for timing. The sample is taken, and the next sample comes `bit_width_i` edges later.
- R7: Rising edges and long runs of equal bits (including stuff bits) do not move the timing. One strobe is produced per bit period regardless of data.
- R8: `bit_width_i` and `sample_ofs_i` are captured only while idle, including at the start-of-frame edge. Changes during a frame have no effect until the next frame.
- R9: `frame_done_i` during a frame returns the block to idle at that edge. It overrides a sample due at the same edge, so no strobe follows. While idle, `frame_done_i` is ignored.
- R10: `bit_strobe_o` is a single-cycle pulse for bit widths of 2 or more. `bit_o` changes only together with a strobe. Valid settings are `bit_width_i` ≥ 2 and 1 ≤ `sample_ofs_i` < `bit_width_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Synchronised receive line, 0 = dominant |
| frame_done_i | input | 1 | Return to idle (end of frame) |
| bit_width_i | input | CNT_W | Clock cycles per bit |
| sample_ofs_i | input | CNT_W | Sample point offset from the bit edge, in clocks |
| bit_o | output | 1 | Last sampled bit value |
| bit_strobe_o | output | 1 | One-cycle pulse marking a new `bit_o` |
| sof_o | output | 1 | One-cycle pulse after start of frame is detected |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a falling line edge and a sample point. The bench drives a start bit, then holds the line recessive for exactly offset + width − 1 cycles, so the next fall lands on the second sample point. The reference model must then see the sample taken and the following one a full bit width later (R6).

The second pair is end of frame and a sample point. `frame_done_i` is raised exactly on the first sample point, and the model expects no strobe (R9).

A behavioural model computes every sample time from the recorded edge time and bit count. It is compared with all three outputs on every cycle.

// File: rtl/can_smp_pkg.sv
package can_smp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smp_state_e;
endpackage

// File: rtl/can_smp_edge.sv
module can_smp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= rx_i;
  end

  assign fall_o = prev_q & ~rx_i;
endmodule

// File: rtl/can_smp_cfg.sv
module can_smp_cfg #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] bw_i,
  input  logic [CNT_W-1:0] ofs_i,
  output logic [CNT_W-1:0] bw_o,
  output logic [CNT_W-1:0] ofs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bw_o  <= '0;
      ofs_o <= '0;
    end else if (load_i) begin
      bw_o  <= bw_i;
      ofs_o <= ofs_i;
    end
  end
endmodule

// File: rtl/can_smp_timer.sv
module can_smp_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             resync_i,
  input  logic [CNT_W-1:0] ofs_start_i,
  input  logic [CNT_W-1:0] ofs_i,
  input  logic [CNT_W-1:0] bw_i,
  output logic             due_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= ofs_start_i - ONE;
    end else if (run_i) begin
      if (cnt_q == '0)   cnt_q <= bw_i - ONE;   // sample wins over a coincident edge
      else if (resync_i) cnt_q <= ofs_i - ONE;
      else               cnt_q <= cnt_q - ONE;
    end else begin
      cnt_q <= '0;
    end
  end

  assign due_o = run_i && (cnt_q == '0);

  // R4: countdown never exceeds one bit period for valid settings
  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && (ofs_i != '0) && (ofs_i < bw_i)) |-> (cnt_q < bw_i));
endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
  import can_smp_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             frame_done_i,
  input  logic [CNT_W-1:0] bit_width_i,
  input  logic [CNT_W-1:0] sample_ofs_i,
  output logic             bit_o,
  output logic             bit_strobe_o,
  output logic             sof_o
);
  smp_state_e       state_q, state_d;
  logic [CNT_W-1:0] bw_q, ofs_q;
  logic             idle, run, fall, due;
  logic             sof_det, done, take, resync;

  assign idle    = (state_q == ST_IDLE);
  assign run     = (state_q == ST_RUN);
  assign sof_det = idle && !rx_i;
  assign done    = run && frame_done_i;
  assign take    = due && !done;
  assign resync  = run && fall && !due && !done;

  can_smp_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .fall_o (fall)
  );

  can_smp_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (idle),
    .bw_i   (bit_width_i),
    .ofs_i  (sample_ofs_i),
    .bw_o   (bw_q),
    .ofs_o  (ofs_q)
  );

  can_smp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (sof_det),
    .run_i       (run),
    .resync_i    (resync),
    .ofs_start_i (sample_ofs_i),
    .ofs_i       (ofs_q),
    .bw_i        (bw_q),
    .due_o       (due)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (sof_det) state_d = ST_RUN;
      ST_RUN:  if (done)    state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      bit_o        <= 1'b1;
      bit_strobe_o <= 1'b0;
      sof_o        <= 1'b0;
    end else begin
      state_q      <= state_d;
      sof_o        <= sof_det;
      bit_strobe_o <= take;
      if (take) bit_o <= rx_i;
    end
  end

  // R2: start of frame only after a dominant sample, single pulse
  a_r2_sof_dominant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> $past(!rx_i));
  a_r2_sof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);
  // R3: strobes only come out of a running frame
  a_r3_strobe_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_strobe_o |-> $past(state_q == ST_RUN));
  // R9: end of frame blocks a coincident sample
  a_r9_done_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && run) |=> !bit_strobe_o);
  // R10: single-cycle strobe for widths of 2 or more
  a_r10_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_strobe_o && (bw_q > CNT_W'(1))) |=> !bit_strobe_o);
  // R10: bit value moves only with a strobe
  a_r10_bit_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_strobe_o |-> $stable(bit_o) || $past(!rst_ni));
endmodule

// File: tb/can_bit_sampler_tb_top.sv
module can_bit_sampler_tb_top;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx = 1'b1;
  logic             done = 1'b0;
  logic [CNT_W-1:0] bw = 12'd10;
  logic [CNT_W-1:0] ofs = 12'd7;
  logic             bit_w, stb_w, sof_w;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  logic [1:0] wq[$];

  always #5 clk = ~clk;

  can_bit_sampler #(.CNT_W(CNT_W)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_i         (rx),
    .frame_done_i (done),
    .bit_width_i  (bw),
    .sample_ofs_i (ofs),
    .bit_o        (bit_w),
    .bit_strobe_o (stb_w),
    .sof_o        (sof_w)
  );

  // Reference model: sample time = ref edge + (bits since ref) * width + offset
  int   cyc, ref_t, ref_n, nbits, m_bw, m_ofs;
  bit   m_run, prev_rx, e_bit, e_stb, e_sof;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; ref_t = 0; ref_n = 0; nbits = 0; m_bw = 0; m_ofs = 0;
      m_run = 0; prev_rx = 1; e_bit = 1; e_stb = 0; e_sof = 0;
    end else begin
      cyc++;
      e_stb = 0;
      e_sof = 0;
      if (m_run) begin
        if (done) m_run = 0;
        else if (cyc == ref_t + (nbits - ref_n) * m_bw + m_ofs) begin
          e_stb = 1; e_bit = rx; nbits++;
        end else if (prev_rx && !rx) begin
          ref_t = cyc; ref_n = nbits;
        end
      end else begin
        m_bw = int'(bw); m_ofs = int'(ofs);
        if (!rx) begin
          m_run = 1; e_sof = 1; ref_t = cyc; ref_n = 0; nbits = 0;
        end
      end
      prev_rx = rx;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if (bit_w !== e_bit || stb_w !== e_stb || sof_w !== e_sof) begin
        n_bad++;
        $display("FAIL %s t=%0t bit/stb/sof actual %b%b%b expected %b%b%b",
                 cur_req, $time, bit_w, stb_w, sof_w, e_bit, e_stb, e_sof);
      end
    end
  end

  task automatic push(input bit r, input bit d, input int n);
    for (int i = 0; i < n; i++) wq.push_back({d, r});
  endtask

  task automatic play();
    while (wq.size() > 0) begin
      @(negedge clk);
      {done, rx} = wq.pop_front();
    end
    @(negedge clk);
    done = 1'b0;
  endtask

  // Drive bit list with a given transmitter period, then end the frame
  task automatic frame(input bit b[], input int per);
    foreach (b[i]) push(b[i], 1'b0, per);
    push(1'b1, 1'b1, 1);
    push(1'b1, 1'b0, 15);
    play();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; push(1'b1, 1'b0, 5); play();
    cur_req = "R2"; push(1'b1, 1'b1, 3); push(1'b1, 1'b0, 15); play();
    cur_req = "R3 R4";
    frame('{0,1,1,0,1,0,0,0,0,0,1,1,1,0,1,1}, 10);
    cur_req = "R5 slow";
    frame('{0,1,0,1,1,0,1,0,0,1,0,1,1,1,0,0,1,0,1,1}, 11);
    cur_req = "R5 fast";
    frame('{0,1,0,1,1,0,1,0,0,1,0,1,1,1,0,0,1,0,1,1}, 9);
    cur_req = "R7";
    frame('{0,0,0,0,0,1,1,1,1,1,1,1,1,0,0,0}, 10);
    // R6: falling edge exactly on the second sample point
    cur_req = "R6";
    push(1'b0, 1'b0, 1); push(1'b1, 1'b0, 7 + 10 - 1); push(1'b0, 1'b0, 40);
    push(1'b1, 1'b1, 1); push(1'b1, 1'b0, 15); play();
    // R5: falling edge one cycle before the pending sample
    cur_req = "R5 early";
    push(1'b0, 1'b0, 1); push(1'b1, 1'b0, 7 + 10 - 2); push(1'b0, 1'b0, 40);
    push(1'b1, 1'b1, 1); push(1'b1, 1'b0, 15); play();
    // R9: end of frame on the first sample point, then done while idle
    cur_req = "R9";
    push(1'b0, 1'b0, 1); push(1'b1, 1'b0, 6); push(1'b1, 1'b1, 1);
    push(1'b1, 1'b0, 20); push(1'b1, 1'b1, 3); push(1'b1, 1'b0, 10); play();
    // R8: settings changed mid frame are ignored, used in next frame
    cur_req = "R8";
    push(1'b0, 1'b0, 20);
    play();
    bw = 12'd5; ofs = 12'd3;
    push(1'b1, 1'b0, 20); push(1'b0, 1'b0, 10); push(1'b1, 1'b0, 30);
    push(1'b1, 1'b1, 1); push(1'b1, 1'b0, 10); play();
    cur_req = "R8 R10";
    frame('{0,1,0,0,1,1,0,1,0,1,1,1,0,1}, 5);
    cur_req = "R10";
    bw = 12'd2; ofs = 12'd1;
    frame('{0,1,0,1,1,0,0,1,0,1}, 2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule